// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Dead Time

This block drives one PWM pin from a shared up/down timebase instead of a private counter. The shared counter starts a period at 1, counts up to its peak P, then counts down to 2, so one PWM period lasts 2P−2 clock ticks. The counter also supplies a direction flag and a strobe that marks the period start. The channel compares the counter value against a duty threshold T. On the rising half it turns its pulse on, and on the falling half it turns the pulse off, so the pulse is centered on the peak.

A dead-time value DT trims the pulse on one selectable edge. In leading mode the switch-on is delayed: the rising-half threshold becomes T+DT. In trailing mode the switch-off is advanced: the falling-half threshold becomes T+DT. The threshold, dead time, edge select and polarity are held in shadow registers. These registers load only on the period strobe, so a software write never produces a partial period. The shared counter lives outside the block, and there is one output per channel.

Top module: `cpwm_dt`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is 0. Reset clears the shadows to threshold 0, dead time 0, trailing mode and active-high polarity.
- R2: Each counter tick presented at a clock edge is reflected on `pwm_out` after that edge. The output is registered, with one cycle of latency.
- R3: With DT=0 and 2 ≤ T ≤ P, the pulse turns on at the rising-half tick where the count equals T. It stays on through the falling-half ticks whose count is ≥ T, which gives 2P−2T+1 active ticks per period.
- R4: T ≤ 1 with DT=0 keeps the output active on all 2P−2 ticks. T > P keeps it inactive for the whole period.
- R5: In leading mode (`dead_lead`=1) the pulse turns on at the rising-half count T+DT, and the active width drops to 2P−2T+1−DT.
- R6: In leading mode, if T+DT > P the output stays inactive for the whole period.
- R7: In trailing mode (`dead_lead`=0) the pulse turns on at the rising-half count T. It turns off at the first falling-half tick whose count is below T+DT. If T+DT ≥ P, only the rising-half ticks from T to P remain active.
- R8: `active_low`=1 inverts the pin, so an active tick drives 0 and an inactive tick drives 1.
- R9: `duty_thr`, `dead_ticks`, `dead_lead` and `active_low` are sampled only on a tick with `tb_sync`=1. Changes between strobes have no effect until the next period.
- R10: Apart from the strobe tick, the pulse never turns on during a falling-half tick and never turns off during a rising-half tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one timebase tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_count | input | W | Shared timebase count |
| tb_down | input | 1 | 1 while the shared counter is in its falling half |
| tb_sync | input | 1 | Period-start strobe, high on the tick where the count is 1 |
| duty_thr | input | W | Duty threshold T |
| dead_ticks | input | W | Dead time DT in ticks |
| dead_lead | input | 1 | 1 = dead time on the switch-on edge, 0 = on the switch-off edge |
| active_low | input | 1 | 1 = active-low pin |
| pwm_out | output | 1 | PWM pin |

## Verification
The bound checker watches, on every cycle, that the pulse changes only in the direction allowed for the current counter half (R10). It also checks that the shadow registers move only on the strobe (R9), and that the strobe tick turns the pulse on or off as the new threshold dictates (R4). Exact pulse widths and switch-on positions for each dead-time mode, the suppression corner, polarity inversion, and deferral of writes made in the middle of a period can only be shown by the bench. The bench drives whole periods of the modelled counter and counts the active ticks.

// File: rtl/cpwm_dt.sv
module cpwm_dt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tb_count,
  input  logic         tb_down,
  input  logic         tb_sync,
  input  logic [W-1:0] duty_thr,
  input  logic [W-1:0] dead_ticks,
  input  logic         dead_lead,
  input  logic         active_low,
  output logic         pwm_out
);
  localparam int XW = W + 1;

  logic [W-1:0] duty_q, dead_q;
  logic         lead_q, pol_q, st;

  wire [W-1:0]  duty_n = tb_sync ? duty_thr   : duty_q;
  wire [W-1:0]  dead_n = tb_sync ? dead_ticks : dead_q;
  wire          lead_n = tb_sync ? dead_lead  : lead_q;
  wire          pol_n  = tb_sync ? active_low : pol_q;

  wire [XW-1:0] base   = {1'b0, duty_n};
  wire [XW-1:0] late   = base + {1'b0, dead_n};
  wire [XW-1:0] up_thr = lead_n ? late : base;
  wire [XW-1:0] dn_thr = lead_n ? base : late;
  wire [XW-1:0] cnt_x  = {1'b0, tb_count};

  logic st_next;
  always_comb begin
    if (tb_sync)       st_next = cnt_x >= up_thr;
    else if (!tb_down) st_next = st | (cnt_x >= up_thr);
    else               st_next = st & (cnt_x >= dn_thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q  <= '0;
      dead_q  <= '0;
      lead_q  <= 1'b0;
      pol_q   <= 1'b0;
      st      <= 1'b0;
      pwm_out <= 1'b0;
    end else begin
      duty_q  <= duty_n;
      dead_q  <= dead_n;
      lead_q  <= lead_n;
      pol_q   <= pol_n;
      st      <= st_next;
      pwm_out <= st_next ^ pol_n;
    end
  end
endmodule

// File: rtl/cpwm_dt_chk.sv
module cpwm_dt_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] tb_count,
  input logic         tb_down,
  input logic         tb_sync,
  input logic [W-1:0] duty_thr,
  input logic [W-1:0] dead_ticks,
  input logic         pwm_out,
  input logic         pol_q,
  input logic [W-1:0] duty_q,
  input logic [W-1:0] dead_q
);
  wire raw = pwm_out ^ pol_q;

  a_r10_no_rise_falling: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_down && !tb_sync) |=> !$rose(raw));

  a_r10_no_fall_rising: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_down && !tb_sync) |=> !$fell(raw));

  a_r9_hold_between_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_sync |=> ($stable(duty_q) && $stable(dead_q) && $stable(pol_q)));

  a_r9_load_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    tb_sync |=> (duty_q == $past(duty_thr) && dead_q == $past(dead_ticks)));

  a_r4_full_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_sync && tb_count == 1 && duty_thr <= 1 && dead_ticks == 0) |=> raw);

  a_r3_off_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_sync && tb_count == 1 && duty_thr > 1) |=> !raw);
endmodule

bind cpwm_dt cpwm_dt_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_down(tb_down),
  .tb_sync(tb_sync), .duty_thr(duty_thr), .dead_ticks(dead_ticks),
  .pwm_out(pwm_out), .pol_q(pol_q), .duty_q(duty_q), .dead_q(dead_q)
);

// File: tb/cpwm_dt_test.sv
module cpwm_dt_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] tb_count = '0;
  logic tb_down = 1'b0, tb_sync = 1'b0;
  logic [W-1:0] duty_thr = '0, dead_ticks = '0;
  logic dead_lead = 1'b0, active_low = 1'b0;
  logic pwm_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cpwm_dt #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_down(tb_down),
    .tb_sync(tb_sync), .duty_thr(duty_thr), .dead_ticks(dead_ticks),
    .dead_lead(dead_lead), .active_low(active_low), .pwm_out(pwm_out)
  );

  // P, T, DT, lead, pol, expected width, expected first active tick
  localparam int NV = 13;
  localparam int VEC [NV][7] = '{
    '{10,  4, 0, 1, 0, 13,  3},  // R3
    '{10,  4, 3, 1, 0, 10,  6},  // R5
    '{10,  4, 3, 0, 0, 10,  3},  // R7
    '{10,  4, 7, 1, 0,  0, -1},  // R6
    '{10,  4, 6, 1, 0,  7,  9},  // R5 edge
    '{10,  1, 0, 0, 0, 18,  0},  // R4
    '{10, 11, 0, 0, 0,  0, -1},  // R4
    '{10, 10, 0, 0, 0,  1,  9},  // R3
    '{10,  4, 8, 0, 0,  7,  3},  // R7
    '{10,  4, 0, 0, 1, 13,  3},  // R8
    '{ 6,  3, 2, 0, 0,  5,  2},  // R7
    '{ 6,  2, 0, 1, 0,  9,  1},  // R3
    '{10,  0, 0, 1, 0, 18,  0}   // R4
  };

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_period(input int p, input int chg, input logic [W-1:0] nd,
                            input logic [W-1:0] ndt, input logic npol,
                            input logic pol_meas, output int width, output int first);
    width = 0;
    first = -1;
    for (int i = 0; i < 2*p-2; i++) begin
      @(negedge clk);
      if (i == chg) begin
        duty_thr = nd;
        dead_ticks = ndt;
        active_low = npol;
      end
      tb_sync  = (i == 0);
      tb_down  = (i >= p);
      tb_count = (i < p) ? W'(i + 1) : W'(2*p - 1 - i);
      @(posedge clk);
      #1;
      if (pwm_out != pol_meas) begin
        width++;
        if (first < 0) first = i;
      end
    end
  endtask

  initial begin
    #(10 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w, f;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset level", int'(pwm_out), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      duty_thr   = W'(VEC[v][1]);
      dead_ticks = W'(VEC[v][2]);
      dead_lead  = VEC[v][3][0];
      active_low = VEC[v][4][0];
      run_period(VEC[v][0], -1, '0, '0, 1'b0, VEC[v][4][0], w, f);
      check($sformatf("R3/R5/R6/R7/R8 width vec%0d", v), w, VEC[v][5]);
      check($sformatf("R2 first active tick vec%0d", v), f, VEC[v][6]);
    end

    // R9: mid-period writes wait for the next strobe
    @(negedge clk);
    duty_thr = 4; dead_ticks = 0; dead_lead = 1'b1; active_low = 1'b0;
    run_period(10, 5, 16'd8, 16'd2, 1'b1, 1'b0, w, f);
    check("R9 current period width", w, 13);
    check("R9 current period first", f, 3);
    run_period(10, -1, '0, '0, 1'b0, 1'b1, w, f);
    check("R9 next period width", w, 3);
    check("R9 next period first", f, 9);

    // R1: reset returns the pin low even mid-pulse
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", int'(pwm_out), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule